// File: doc/BRIEF.md
# Permuted Multi-Dimensional Element Index Generator

This block produces, one element per clock, the element indices that a vector loop uses when a register is reshaped. The register's elements are treated as an array of up to three dimensions. The loop can walk the dimensions in any of six nesting orders, and a small constant offset is added to every index. A single 32-bit shape word sets the dimension sizes, the offset and the nesting order.

A controller pulses `start_i` with a shape word and then holds `step_i` high for as long as it can consume elements. While `valid_o` is high, `idx_o` carries the current remapped index. `last_o` marks the final element of the walk. A start with an illegal order code raises `err_o` and starts no walk.

Top module: `remap_index_gen`

## Requirements
- R1: During and immediately after reset, `valid_o`, `last_o` and `err_o` are 0 and `idx_o` is 0.
- R2: A `start_i` sampled at a clock edge with a legal order code makes `valid_o` 1 after that edge, with every counter at zero, so `idx_o` equals the offset. A start is accepted whether or not a walk is running; it discards the running walk and restarts from zero with the new shape.
- R3: Shape word fields: X size in bits 6:0, Y size in bits 14:8, Z size in bits 22:16, order code in bits 26:24. The 3-bit offset sits at bit 7 (LSB), bit 15 (middle bit) and bit 23 (MSB).
- R4: Each size field holds the dimension length minus one. A field value of 0 is a length of 1, and a field value of 127 is a length of 128.
- R5: `idx_o = offs + ix + iy*X + iz*X*Y`, where X and Y are the true lengths and ix, iy, iz are the counters.
- R6: Order codes 0 to 5 nest the dimensions, fastest first, as x-y-z, x-z-y, y-x-z, y-z-x, z-x-y and z-y-x. The fastest dimension advances on each step. A dimension at its last value wraps to 0 and carries into the next one in the order.
- R7: A walk produces exactly X*Y*Z valid elements, one per accepted step. `last_o` is 1 only while the final element is presented.
- R8: A step on the final element drops `valid_o` after that edge and returns all counters to zero, so the idle `idx_o` equals the offset.
- R9: Order codes 6 and 7 are illegal. A start carrying one of them sets `err_o`, leaves `valid_o` at 0 and leaves `idx_o` unchanged. A later start with a legal code clears `err_o`.
- R10: `step_i` has no effect while `valid_o` is 0. While `valid_o` is 1, a cycle with `step_i` low holds the current element.
- R11: An all-zero shape word gives a one-element walk whose index is 0, the plain linear index. `last_o` is 1 on that element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shape_i | input | 32 | Shape word, sampled when `start_i` is 1 |
| start_i | input | 1 | Begin a new walk with `shape_i` |
| step_i | input | 1 | Advance to the next element |
| idx_o | output | 22 | Remapped element index |
| valid_o | output | 1 | `idx_o` is a live element of the walk |
| last_o | output | 1 | Current element is the final one |
| err_o | output | 1 | Last start carried an illegal order code |

## Verification
Every result appears one edge after the stimulus that causes it. The first element and `err_o` appear after the edge that samples `start_i`. Each following element appears after the edge that samples a step, and the idle state follows the step on the final element. The bench drives inputs just after a rising edge and compares on the falling edge. For each walk, a reference model in the bench queues the expected index and last flag of every element. With `step_i` held high, the monitor pops one queued entry for each falling edge at which `valid_o` is 1, so any extra, missing or shifted element shows up as a miscompare or as a non-empty queue.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int N_DIM  = 3;
    localparam int DIM_W  = 7;
    localparam int OFF_W  = 3;
    localparam int PERM_W = 3;
    localparam int FLD_STRIDE = DIM_W + 1;
    localparam int PERM_LSB   = N_DIM * FLD_STRIDE;
    localparam int SHAPE_W    = 32;
    localparam int IDX_W      = N_DIM * DIM_W + 1;
    localparam int N_PERM     = 6;

    typedef logic [DIM_W-1:0] dim_t;
    typedef logic [N_DIM-1:0][DIM_W-1:0] cnt_t;
    typedef logic [N_DIM-1:0][1:0] ord_t;

    typedef struct packed {
        cnt_t               lim;
        logic [OFF_W-1:0]   offs;
        logic [PERM_W-1:0]  perm;
    } shape_t;

    function automatic ord_t perm_order(input logic [PERM_W-1:0] p);
        ord_t o;
        case (p)
            3'd1:    begin o[0] = 2'd0; o[1] = 2'd2; o[2] = 2'd1; end
            3'd2:    begin o[0] = 2'd1; o[1] = 2'd0; o[2] = 2'd2; end
            3'd3:    begin o[0] = 2'd1; o[1] = 2'd2; o[2] = 2'd0; end
            3'd4:    begin o[0] = 2'd2; o[1] = 2'd0; o[2] = 2'd1; end
            3'd5:    begin o[0] = 2'd2; o[1] = 2'd1; o[2] = 2'd0; end
            default: begin o[0] = 2'd0; o[1] = 2'd1; o[2] = 2'd2; end
        endcase
        return o;
    endfunction
endpackage

// File: rtl/remap_shape_dec.sv
module remap_shape_dec
    import remap_pkg::*;
(
    input  logic [SHAPE_W-1:0] word_i,
    output shape_t             cfg_o,
    output logic               bad_o
);
    for (genvar g = 0; g < N_DIM; g++) begin : g_field
        assign cfg_o.lim[g]  = word_i[g*FLD_STRIDE +: DIM_W];
        assign cfg_o.offs[g] = word_i[g*FLD_STRIDE + DIM_W];
    end
    assign cfg_o.perm = word_i[PERM_LSB +: PERM_W];
    assign bad_o      = (cfg_o.perm >= PERM_W'(N_PERM));
endmodule

// File: rtl/remap_ctr_step.sv
module remap_ctr_step
    import remap_pkg::*;
(
    input  shape_t cfg_i,
    input  cnt_t   cnt_i,
    output cnt_t   nxt_o,
    output logic   last_o
);
    ord_t ord;
    logic carry;

    always_comb begin
        ord   = perm_order(cfg_i.perm);
        nxt_o = cnt_i;
        carry = 1'b1;
        for (int k = 0; k < N_DIM; k++) begin
            if (carry) begin
                if (cnt_i[ord[k]] == cfg_i.lim[ord[k]]) begin
                    nxt_o[ord[k]] = '0;
                end else begin
                    nxt_o[ord[k]] = cnt_i[ord[k]] + 1'b1;
                    carry         = 1'b0;
                end
            end
        end
        last_o = carry;
    end
endmodule

// File: rtl/remap_idx_calc.sv
module remap_idx_calc
    import remap_pkg::*;
(
    input  shape_t           cfg_i,
    input  cnt_t             cnt_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] xs, ys, plane;

    always_comb begin
        xs    = IDX_W'(cfg_i.lim[0]) + IDX_W'(1);
        ys    = IDX_W'(cfg_i.lim[1]) + IDX_W'(1);
        plane = xs * ys;
        idx_o = IDX_W'(cfg_i.offs) + IDX_W'(cnt_i[0])
              + IDX_W'(cnt_i[1]) * xs
              + IDX_W'(cnt_i[2]) * plane;
    end
endmodule

// File: rtl/remap_index_gen.sv
module remap_index_gen
    import remap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SHAPE_W-1:0] shape_i,
    input  logic               start_i,
    input  logic               step_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               valid_o,
    output logic               last_o,
    output logic               err_o
);
    typedef struct packed {
        shape_t cfg;
        cnt_t   cnt;
        logic   act;
        logic   err;
    } st_t;

    st_t    st_d, st_q;
    shape_t dec_cfg;
    logic   dec_bad;
    cnt_t   cnt_nxt;
    logic   at_last;

    remap_shape_dec u_dec (
        .word_i (shape_i),
        .cfg_o  (dec_cfg),
        .bad_o  (dec_bad)
    );

    remap_ctr_step u_step (
        .cfg_i  (st_q.cfg),
        .cnt_i  (st_q.cnt),
        .nxt_o  (cnt_nxt),
        .last_o (at_last)
    );

    remap_idx_calc u_idx (
        .cfg_i  (st_q.cfg),
        .cnt_i  (st_q.cnt),
        .idx_o  (idx_o)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            if (dec_bad) begin
                st_d.err = 1'b1;
                st_d.act = 1'b0;
            end else begin
                st_d.cfg = dec_cfg;
                st_d.cnt = '0;
                st_d.act = 1'b1;
                st_d.err = 1'b0;
            end
        end else if (step_i && st_q.act) begin
            st_d.cnt = cnt_nxt;
            if (at_last) st_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.act;
    assign last_o  = st_q.act & at_last;
    assign err_o   = st_q.err;

    a_r7_last_only_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    a_r9_err_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o);

    a_r2_start_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !dec_bad) |=> (valid_o && idx_o == IDX_W'($past(dec_cfg.offs))));

    a_r8_final_step_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && step_i && !start_i) |=> (!valid_o && idx_o == IDX_W'(st_q.cfg.offs)));

    a_r7_midwalk_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i) |=> valid_o);

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> ($stable(idx_o) && !valid_o));
endmodule

// File: tb/sim_remap_index_gen.sv
`timescale 1ns/1ps
module sim_remap_index_gen;
    import remap_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [SHAPE_W-1:0] shape_i = '0;
    logic               start_i = 1'b0;
    logic               step_i = 1'b0;
    logic [IDX_W-1:0]   idx_o;
    logic               valid_o, last_o, err_o;

    always #2 clk = ~clk;

    remap_index_gen u0 (
        .clk(clk), .rst_n(rst_n), .shape_i(shape_i), .start_i(start_i),
        .step_i(step_i), .idx_o(idx_o), .valid_o(valid_o),
        .last_o(last_o), .err_o(err_o)
    );

    typedef struct {
        int    idx;
        bit    last;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   mon_en = 1'b0;
    bit   finished = 1'b0;

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R3: field positions, offset bits scattered at 7 / 15 / 23
    function automatic logic [31:0] mk(input int x, input int y, input int z,
                                       input int off, input int perm);
        logic [31:0] w;
        w = '0;
        w[6:0]   = 7'(x);
        w[14:8]  = 7'(y);
        w[22:16] = 7'(z);
        w[7]     = off[0];
        w[15]    = off[1];
        w[23]    = off[2];
        w[26:24] = 3'(perm);
        return w;
    endfunction

    // reference model: push every expected element of a walk
    task automatic model(input string req, input int x, input int y, input int z,
                         input int off, input int perm);
        int ordt[6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
        int lim[3];
        int c[3];
        int total;
        exp_t e;
        lim[0] = x + 1; lim[1] = y + 1; lim[2] = z + 1;
        c[0] = 0; c[1] = 0; c[2] = 0;
        total = lim[0] * lim[1] * lim[2];
        for (int n = 0; n < total; n++) begin
            e.idx  = off + c[0] + c[1] * lim[0] + c[2] * lim[0] * lim[1];
            e.last = (n == total - 1);
            e.req  = req;
            q.push_back(e);
            for (int k = 0; k < 3; k++) begin
                int d;
                d = ordt[perm][k];
                c[d] = c[d] + 1;
                if (c[d] != lim[d]) break;
                c[d] = 0;
            end
        end
    endtask

    always @(negedge clk) begin
        if (mon_en && rst_n && valid_o) begin
            exp_t e;
            if (q.size() == 0) begin
                check("R7 extra element", 1, 0);
            end else begin
                e = q.pop_front();
                check({e.req, " idx"}, int'(idx_o), e.idx);
                check({e.req, " last"}, int'(last_o), int'(e.last));
            end
        end
    end

    task automatic pulse_start(input logic [31:0] w);
        @(posedge clk); #1;
        shape_i = w; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic run_walk(input string req, input int x, input int y, input int z,
                            input int off, input int perm);
        model(req, x, y, z, off, perm);
        mon_en = 1'b1;
        pulse_start(mk(x, y, z, off, perm));
        step_i = 1'b1;
        do @(negedge clk); while (valid_o);
        step_i = 1'b0;
        mon_en = 1'b0;
        check({req, " R7 element count"}, q.size(), 0);
        q.delete();
        // R8: counters back at zero, idle index is the offset
        check("R8 idle idx", int'(idx_o), off);
        check("R8 idle valid", int'(valid_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int hold;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid", int'(valid_o), 0);
        check("R1 last", int'(last_o), 0);
        check("R1 err", int'(err_o), 0);
        check("R1 idx", int'(idx_o), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", int'(valid_o), 0);

        // R6 all six orders, with R5 offset and R2 origin
        for (int p = 0; p < 6; p++) run_walk("R6", 2, 3, 4, 5, p);
        run_walk("R5", 3, 1, 2, 7, 0);
        run_walk("R3 offs LSB", 1, 1, 1, 1, 3);
        run_walk("R3 offs MSB", 1, 1, 1, 4, 4);
        run_walk("R4 max x", 127, 0, 0, 2, 0);
        run_walk("R4 max z order", 0, 1, 127, 0, 5);
        run_walk("R11", 0, 0, 0, 0, 0);
        check("R11 shape word", int'(mk(0, 0, 0, 0, 0)), 0);

        // R2 first element visible right after the start edge
        pulse_start(mk(2, 2, 0, 6, 2));
        @(negedge clk);
        check("R2 valid", int'(valid_o), 1);
        check("R2 idx", int'(idx_o), 6);
        // R10 no step holds the element
        repeat (3) @(negedge clk);
        check("R10 hold idx", int'(idx_o), 6);
        check("R10 hold valid", int'(valid_o), 1);
        // one step with order 2: y fastest, idx = 6 + 3
        @(posedge clk); #1; step_i = 1'b1;
        @(posedge clk); #1; step_i = 1'b0;
        @(negedge clk);
        check("R6 single step", int'(idx_o), 9);
        // R2 restart in mid walk
        pulse_start(mk(4, 0, 0, 1, 0));
        @(negedge clk);
        check("R2 restart idx", int'(idx_o), 1);
        check("R2 restart last", int'(last_o), 0);
        @(posedge clk); #1; step_i = 1'b1;
        repeat (4) @(posedge clk);
        #1; step_i = 1'b0;
        @(negedge clk);
        check("R7 last flag", int'(last_o), 1);
        check("R7 last idx", int'(idx_o), 5);
        @(posedge clk); #1; step_i = 1'b1;
        @(posedge clk); #1; step_i = 1'b0;
        @(negedge clk);
        check("R8 ended", int'(valid_o), 0);
        hold = int'(idx_o);
        check("R8 idle idx", hold, 1);

        // R10 stepping while idle does nothing
        @(posedge clk); #1; step_i = 1'b1;
        repeat (3) @(posedge clk);
        #1; step_i = 1'b0;
        @(negedge clk);
        check("R10 idle idx", int'(idx_o), hold);
        check("R10 idle valid", int'(valid_o), 0);

        // R9 reserved order codes
        pulse_start(mk(3, 3, 3, 2, 6));
        @(negedge clk);
        check("R9 err 6", int'(err_o), 1);
        check("R9 valid 6", int'(valid_o), 0);
        check("R9 idx 6", int'(idx_o), hold);
        @(posedge clk); #1; step_i = 1'b1;
        repeat (2) @(posedge clk);
        #1; step_i = 1'b0;
        pulse_start(mk(0, 0, 0, 3, 7));
        @(negedge clk);
        check("R9 err 7", int'(err_o), 1);
        check("R9 valid 7", int'(valid_o), 0);
        check("R9 idx 7", int'(idx_o), hold);
        pulse_start(mk(0, 0, 0, 3, 1));
        @(negedge clk);
        check("R9 err cleared", int'(err_o), 0);
        check("R9 legal start valid", int'(valid_o), 1);
        check("R9 legal start idx", int'(idx_o), 3);

        repeat (2) @(posedge clk);
        report();
    end
endmodule